// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo stream of two's-complement audio carried on three wires (a bit clock, a word-select line that marks the active channel, and a serial data line) and turns it into parallel 24-bit left and right samples. A two-bit format input picks one of four framings. Two carry the most significant bit first at the start of a channel slot: one with a one-bit delay after the word-select change and a low-means-left polarity, one with no delay and a high-means-left polarity. Two right-justified framings take the most recent 24 or 16 bits before the word-select change. 16-bit samples are sign-extended to 24 bits.

The three serial lines are brought into a faster system clock through synchronizers, and the rising edges of the bit clock are found by oversampling. Each completed slot is assigned to a channel. Once a right slot completes after a left one, the pair is presented on the outputs together with a single-cycle valid pulse. The bit clock must run at no more than one quarter of the system clock rate.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0 and `left_o` and `right_o` are 0 until the first complete frame is delivered.
- R2: Serial data and word select are sampled on the rising edge of `bclk_i`. A change of the sampled word-select level ends one channel slot and starts the next one. The word-select level during a slot decides which channel the slot belongs to.
- R3: With `fmt_i` = 2'b00, a slot with word select low is the left channel. The MSB is the bit sampled one bit clock after the edge where word select changes, the next 23 bits follow MSB first, and the bit at the change and any bits after the 24th are ignored.
- R4: With `fmt_i` = 2'b01, a slot with word select high is the left channel. The MSB is the bit sampled at the edge where word select changes, 24 bits are taken MSB first, and any later bits in the slot are ignored.
- R5: With `fmt_i` = 2'b10, word select high is left, and the sample is the last 24 bits sampled before the word-select change, the last bit being the LSB. Earlier bits in the slot are ignored.
- R6: With `fmt_i` = 2'b11, word select high is left, and the sample is the last 16 bits before the word-select change, sign-extended to 24 bits.
- R7: `valid_o` pulses for exactly one system clock once per frame, after the right slot completes, and presents the left and right samples of that frame together. Between pulses both sample outputs hold their values.
- R8: A slot whose start edge was not observed (the first slot after reset) is discarded. A right slot with no completed left slot before it produces no pulse, and a left slot that no right slot has yet followed produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select (00, 01, 10, 11 as in R3 to R6) |
| bclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select, channel indicator |
| sd_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle pulse when a new sample pair is presented |

## Verification
A wrong bit position counter or a mis-steered capture shows up as a corrupted sample on the next pulse. The bench therefore fills every bit that must be ignored with ones, so a wrong window changes the delivered value within one frame. A wrong channel polarity swaps or drops pairs, and a wrong pairing state adds or loses a pulse. Frames carry distinct left and right values, and the number of pulses per run is counted, so either fault is reported at the first frame or at the end of the run. A missing sign extension differs from the expected value on the first negative 16-bit sample.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_DELAYED   = 2'b00,  // MSB one bit after the edge, ws low = left
    FMT_ALIGNED   = 2'b01,  // MSB at the edge, ws high = left
    FMT_TAIL_WIDE = 2'b10,  // last wide word before the edge
    FMT_TAIL_NARR = 2'b11   // last narrow word before the edge, sign-extended
  } rx_fmt_e;

  function automatic logic left_level(input rx_fmt_e f);
    return (f == FMT_DELAYED) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_en_o,
  output logic ws_o,
  output logic sd_o
);

  localparam int LAST = STAGES - 1;

  // bit 0: bit clock, bit 1: data, bit 2: word select
  logic [2:0] stg_q [STAGES];
  logic [2:0] stg_d [STAGES];
  logic       bclk_last_q;

  always_comb begin
    stg_d[0] = {ws_i, sd_i, bclk_i};
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= '0;
      end
      bclk_last_q <= 1'b0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
      bclk_last_q <= stg_q[LAST][0];
    end
  end

  assign bit_en_o = stg_q[LAST][0] & ~bclk_last_q;
  assign sd_o     = stg_q[LAST][1];
  assign ws_o     = stg_q[LAST][2];

endmodule

// File: rtl/serial_audio_rx_slot.sv
module serial_audio_rx_slot
  import serial_audio_rx_pkg::*;
#(
  parameter int W = 24,
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rx_fmt_e      fmt_i,
  input  logic         bit_en_i,
  input  logic         ws_i,
  input  logic         sd_i,
  output logic         done_o,
  output logic         done_ws_o,
  output logic [W-1:0] word_o
);

  localparam int PW = $clog2(W + 2) + 1;
  localparam logic [PW-1:0] POS_MAX = '1;

  logic          primed_q, primed_d;
  logic          ws_prev_q, ws_prev_d;
  logic          in_slot_q, in_slot_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  shreg_q, shreg_d;
  logic          done_q, done_d;
  logic          done_ws_q, done_ws_d;
  logic [W-1:0]  word_q, word_d;
  logic          slot_edge;

  assign slot_edge = primed_q && (ws_i != ws_prev_q);

  always_comb begin
    primed_d  = primed_q;
    ws_prev_d = ws_prev_q;
    in_slot_d = in_slot_q;
    pos_d     = pos_q;
    acc_d     = acc_q;
    shreg_d   = shreg_q;
    done_d    = 1'b0;
    done_ws_d = done_ws_q;
    word_d    = word_q;
    if (bit_en_i) begin
      primed_d  = 1'b1;
      ws_prev_d = ws_i;
      shreg_d   = {shreg_q[W-2:0], sd_i};
      if (slot_edge) begin
        done_d    = in_slot_q;
        done_ws_d = ws_prev_q;
        unique case (fmt_i)
          FMT_TAIL_WIDE: word_d = shreg_q;
          FMT_TAIL_NARR: word_d = {{(W-N){shreg_q[N-1]}}, shreg_q[N-1:0]};
          default:       word_d = acc_q;
        endcase
        in_slot_d = 1'b1;
        pos_d     = PW'(1);
        acc_d     = '0;
        if (fmt_i == FMT_ALIGNED) begin
          acc_d[W-1] = sd_i;
        end
      end else begin
        if (pos_q != POS_MAX) begin
          pos_d = pos_q + PW'(1);
        end
        for (int k = 0; k < W; k++) begin
          if (fmt_i == FMT_ALIGNED && pos_q == PW'(W - 1 - k)) begin
            acc_d[k] = sd_i;
          end
          if (fmt_i == FMT_DELAYED && pos_q == PW'(W - k)) begin
            acc_d[k] = sd_i;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      ws_prev_q <= 1'b0;
      in_slot_q <= 1'b0;
      pos_q     <= '0;
      acc_q     <= '0;
      shreg_q   <= '0;
      done_q    <= 1'b0;
      done_ws_q <= 1'b0;
      word_q    <= '0;
    end else begin
      primed_q  <= primed_d;
      ws_prev_q <= ws_prev_d;
      in_slot_q <= in_slot_d;
      pos_q     <= pos_d;
      acc_q     <= acc_d;
      shreg_q   <= shreg_d;
      done_q    <= done_d;
      done_ws_q <= done_ws_d;
      word_q    <= word_d;
    end
  end

  assign done_o    = done_q;
  assign done_ws_o = done_ws_q;
  assign word_o    = word_q;

endmodule

// File: rtl/serial_audio_rx_pair.sv
module serial_audio_rx_pair
  import serial_audio_rx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rx_fmt_e      fmt_i,
  input  logic         done_i,
  input  logic         done_ws_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);

  logic         have_l_q, have_l_d;
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] left_q, left_d;
  logic [W-1:0] right_q, right_d;
  logic         valid_q, valid_d;
  logic         is_left;

  assign is_left = (done_ws_i == left_level(fmt_i));

  always_comb begin
    have_l_d = have_l_q;
    hold_d   = hold_q;
    left_d   = left_q;
    right_d  = right_q;
    valid_d  = 1'b0;
    if (done_i) begin
      if (is_left) begin
        hold_d   = word_i;
        have_l_d = 1'b1;
      end else if (have_l_q) begin
        left_d   = hold_q;
        right_d  = word_i;
        valid_d  = 1'b1;
        have_l_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_l_q <= 1'b0;
      hold_q   <= '0;
      left_q   <= '0;
      right_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      have_l_q <= have_l_d;
      hold_q   <= hold_d;
      left_q   <= left_d;
      right_q  <= right_d;
      valid_q  <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_i,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [1:0]          rst_pipe_q;
  logic                rst_n_sync;
  rx_fmt_e             fmt;
  logic                bit_en, ws_s, sd_s;
  logic                slot_done, slot_ws;
  logic [SAMPLE_W-1:0] slot_word;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign fmt = rx_fmt_e'(fmt_i);

  serial_audio_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .bclk_i   (bclk_i),
    .ws_i     (ws_i),
    .sd_i     (sd_i),
    .bit_en_o (bit_en),
    .ws_o     (ws_s),
    .sd_o     (sd_s)
  );

  serial_audio_rx_slot #(.W(SAMPLE_W), .N(SHORT_W)) i_slot (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .fmt_i     (fmt),
    .bit_en_i  (bit_en),
    .ws_i      (ws_s),
    .sd_i      (sd_s),
    .done_o    (slot_done),
    .done_ws_o (slot_ws),
    .word_o    (slot_word)
  );

  serial_audio_rx_pair #(.W(SAMPLE_W)) i_pair (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .fmt_i     (fmt),
    .done_i    (slot_done),
    .done_ws_i (slot_ws),
    .word_i    (slot_word),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int W = 24,
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   fmt_i,
  input logic         bit_en,
  input logic         slot_done,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!valid_o && left_o == '0 && right_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  assert_slot_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> $past(bit_en));

  assert_narrow_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt_i == 2'b11) |->
      (left_o[W-1:N] == {(W-N){left_o[N-1]}} && right_o[W-1:N] == {(W-N){right_o[N-1]}}));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_pulse_after_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(slot_done));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (left_o != $past(left_o) || right_o != $past(right_o)) |-> valid_o);

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.W(SAMPLE_W), .N(SHORT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .fmt_i     (fmt_i),
  .bit_en    (bit_en),
  .slot_done (slot_done),
  .valid_o   (valid_o),
  .left_o    (left_o),
  .right_o   (right_o)
);

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

  localparam int NF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        bclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [23:0] left, right;
  logic        valid;

  int n_tests = 0, n_fail = 0, cnt_v = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] raw(input int f, input int k, input bit rch);
    logic [23:0] v;
    case (k)
      0: v = 24'h800000;
      1: v = 24'h7FFFFF;
      2: v = 24'hFFFFFF;
      3: v = 24'h000001;
      default: v = (24'(k) * 24'h3A5C71 + 24'(f) * 24'h010F0F) ^ 24'h5A5A5A;
    endcase
    if (rch) v = ~v + 24'(k);
    return v;
  endfunction

  function automatic logic [23:0] expect_val(input int f, input int k, input bit rch);
    logic [23:0] v = raw(f, k, rch);
    if (f == 3) v = {{8{v[15]}}, v[15:0]};  // R6 sign extension
    return v;
  endfunction

  // bit b of a slot, b=0 being the first bit with the new ws level; ignored bits are 1
  function automatic logic slot_bit(input int f, input int b, input logic [23:0] v);
    case (f)
      0: return (b >= 1 && b <= 24) ? v[24-b] : 1'b1;
      1: return (b < 24) ? v[23-b] : 1'b1;
      2: return (b >= 8) ? v[31-b] : 1'b1;
      default: return (b >= 16) ? v[31-b] : 1'b1;
    endcase
  endfunction

  function automatic string tag(input int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic send_bit(input logic w, input logic d);
    bclk = 1'b0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic w, input int f, input logic [23:0] v);
    for (int b = 0; b < 32; b++) send_bit(w, slot_bit(f, b, v));
  endtask

  // monitor: each pulse carries both channels of the next expected frame (R2, R7)
  always @(negedge clk) begin
    if (rst_n && valid) begin
      check(left == expect_val(int'(fmt), cnt_v, 1'b0), tag(int'(fmt)),
            left, expect_val(int'(fmt), cnt_v, 1'b0));
      check(right == expect_val(int'(fmt), cnt_v, 1'b1), tag(int'(fmt)),
            right, expect_val(int'(fmt), cnt_v, 1'b1));
      cnt_v++;
    end
  end

  initial begin
    for (int f = 0; f < 4; f++) begin
      logic lv;
      rst_n = 1'b0; fmt = 2'(f); bclk = 1'b0; ws = 1'b0; sd = 1'b0;
      repeat (5) @(negedge clk);
      check(valid == 1'b0 && left == 24'h0 && right == 24'h0, "R1", left | right, 24'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(valid == 1'b0 && left == 24'h0, "R1", left, 24'h0);
      cnt_v = 0;
      lv = (f == 0) ? 1'b0 : 1'b1;
      // R8: partial right-level slot right after reset, must be dropped
      for (int b = 0; b < 5; b++) send_bit(~lv, 1'b1);
      for (int k = 0; k < NF; k++) begin
        send_slot(lv, f, raw(f, k, 1'b0));
        send_slot(~lv, f, raw(f, k, 1'b1));
      end
      // trailing left slot ends the last right slot; it must not pulse by itself (R8)
      send_slot(lv, f, 24'h123456);
      repeat (10) @(negedge clk);
      check(cnt_v == NF, "R7/R8 pulse count", 24'(cnt_v), 24'(NF));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule